// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. The horizontal axis and the vertical axis are each programmed with four values: active size, front porch, sync width and back porch. From these the block drives horizontal sync, vertical sync and data enable. It also outputs the pixel column and row counters and a scan-out address for the pixel fetch logic. The panel pixel clock is `clk_i`.

Software writes a set of shadow registers. These hold the timing values, a polarity control word, a frame-buffer base offset and a line stride. The whole shadow set is copied into the active set in one step, on the clock edge where vertical blanking begins, so the frame being displayed never changes partway through. Software can pan between two frame buffers stacked in memory by moving the base offset. A one-cycle vblank pulse, a sticky vblank flag and a commit-pending bit tell software when the buffer it just released is safe to rewrite.

Shadow register addresses on `wr_addr_i`:

| Address | Contents |
|---|---|
| 0 | horizontal active size |
| 1 | horizontal front porch |
| 2 | horizontal sync width |
| 3 | horizontal back porch |
| 4 | vertical active size |
| 5 | vertical front porch |
| 6 | vertical sync width |
| 7 | vertical back porch |
| 8 | polarity word |
| 9 | base offset |
| 10 | stride |
| 15 | status clear (write 1 to bit 0) |

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the active and shadow sets both hold the reset parameters. By default these are the 640x480 mode: horizontal active 640, front porch 24, sync 96, back porch 40; vertical active 480, front porch 11, sync 2, back porch 32. The reset polarity word is 4'b1100, base is 0 and stride is the stride parameter. The column and row counters start at 0, and the vblank pulse, vblank flag and commit-pending bit are all 0.
- R2: Within a line, `x_o` counts from 0 to htotal-1, where htotal is the sum of the four horizontal values. The line runs in this order: active, front porch, sync, back porch. Data enable is raw-asserted for x < active while y is also in its active range, and horizontal sync is raw-asserted for active+front ≤ x < active+front+sync.
- R3: `y_o` advances by one at the end of each line and wraps after vtotal-1. Vertical lines follow the same order of active, front porch, sync and back porch, and vertical sync is raw-asserted across the vertical sync window.
- R4: The polarity word sets how each output is driven:
  - bit 0 = 1 makes horizontal sync active high; bit 0 = 0 makes it active low.
  - bit 1 does the same for vertical sync.
  - bit 2 = 1 makes data enable active high.
  - bit 3 = 1 means the panel samples on the rising edge. The sync and enable outputs are then launched on the falling clock edge, so they trail the counters by half a cycle. With bit 3 = 0 they change on the rising edge together with the counters.
- R5: A write to any address from 0 to 10 changes no output until the commit edge. The commit edge is the clock edge that ends the last active line (x = htotal-1, y = vactive-1). On that edge the shadow set becomes active, `x_o` goes to 0 and `y_o` is loaded with the new vertical active size, which is the first front-porch line of the new timing.
- R6: While data enable is raw-asserted, `addr_o` = base + y·stride + x, taken modulo 2^24. Otherwise `addr_o` is 0. This lets software pan between two buffers by setting the base to vactive·stride.
- R7: `vblank_start_o` is high for exactly the one cycle after each commit edge, and `vblank_flag_o` is set on that same edge. Writing address 15 with bit 0 = 1 clears the flag, but a commit edge in the same cycle keeps it set. Writing address 15 with bit 0 = 0 leaves the flag unchanged.
- R8: `commit_pending_o` is set by a write to any of addresses 0 to 10 and cleared on the commit edge. A write in the commit cycle leaves it set. Writes to addresses 11 to 15 do not set it.
- R9: If the shadow set has a zero horizontal or vertical active size, or a zero horizontal or vertical sync width, the commit keeps the previous active set unchanged. The vblank pulse and the clearing of the pending bit still take place.
- R10: The block accepts a mode with 800 active columns, sync from column 824 to 895 and 992 columns in total, and vertical values 480/483/493/500, with active-low horizontal sync and active-high vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | pixel clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 4 | register address |
| wr_data_i | input | 24 | register write data |
| hsync_o | output | 1 | horizontal sync, polarity applied |
| vsync_o | output | 1 | vertical sync, polarity applied |
| de_o | output | 1 | data enable, polarity applied |
| x_o | output | 12 | pixel column counter |
| y_o | output | 12 | line counter |
| addr_o | output | 24 | scan-out address, 0 outside the active area |
| vblank_start_o | output | 1 | one-cycle pulse when vertical blanking begins |
| vblank_flag_o | output | 1 | sticky vblank flag, cleared by writing 1 |
| commit_pending_o | output | 1 | shadow set written but not yet committed |

## Verification
The bench builds the block with a tiny reset mode: horizontal 6/2/3/2 and vertical 4/1/2/1 with a stride of 6. A frame is then only 104 cycles long, so many commits, all sixteen polarity words, panning and rejected shadow sets each fit in a few frames. It then programs the 800-column mode at run time and runs far enough into its vertical blanking to observe the horizontal and vertical sync windows at full size. Because the reset values are parameters, the 640x480 defaults are covered by the same code path that the small mode exercises.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CNT_W    = 12;
  localparam int ADDR_W   = 24;
  localparam int STRIDE_W = 16;
  localparam int RA_W     = 4;
  localparam int DATA_W   = ADDR_W;
  localparam int POL_W    = 4;
  localparam int NUM_TIM  = 8;

  localparam int POL_HS   = 0;
  localparam int POL_VS   = 1;
  localparam int POL_DE   = 2;
  localparam int POL_PCLK = 3;

  localparam logic [RA_W-1:0] RA_POL    = 4'd8;
  localparam logic [RA_W-1:0] RA_BASE   = 4'd9;
  localparam logic [RA_W-1:0] RA_STRIDE = 4'd10;
  localparam logic [RA_W-1:0] RA_STATUS = 4'd15;

  typedef struct packed {
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] fp;
    logic [CNT_W-1:0] sync;
    logic [CNT_W-1:0] bp;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } tim_t;

  typedef struct packed {
    tim_t                tim;
    logic [POL_W-1:0]    pol;
    logic [ADDR_W-1:0]   base;
    logic [STRIDE_W-1:0] stride;
  } mode_t;

  // register index i maps to the i-th field counted from the MSB of tim_t
  function automatic logic [CNT_W-1:0] tim_field(input tim_t t, input int i);
    logic [NUM_TIM*CNT_W-1:0] flat;
    flat = t;
    return flat[(NUM_TIM-1-i)*CNT_W +: CNT_W];
  endfunction
endpackage

// File: rtl/rtg_window.sv
module rtg_window import rtg_pkg::*; (
  input  axis_t            ax_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             in_act_o,
  output logic             in_sync_o,
  output logic             at_last_o
);
  logic [CNT_W-1:0] sync_start, sync_end, total;

  assign sync_start = ax_i.act + ax_i.fp;
  assign sync_end   = sync_start + ax_i.sync;
  assign total      = sync_end + ax_i.bp;

  assign in_act_o  = cnt_i < ax_i.act;
  assign in_sync_o = (cnt_i >= sync_start) && (cnt_i < sync_end);
  assign at_last_o = cnt_i == total - 1'b1;
endmodule

// File: rtl/rtg_cfg.sv
module rtg_cfg import rtg_pkg::*; #(
  parameter mode_t RST_MODE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  output mode_t             act_o,
  output logic [CNT_W-1:0]  next_v_act_o,
  output logic              vblank_start_o,
  output logic              vblank_flag_o,
  output logic              pending_o
);
  logic [NUM_TIM*CNT_W-1:0] sh_flat;
  logic [POL_W-1:0]         sh_pol_q;
  logic [ADDR_W-1:0]        sh_base_q;
  logic [STRIDE_W-1:0]      sh_stride_q;
  mode_t                    shadow, next_mode, act_q;
  logic                     sh_valid, shadow_wr, status_clr;
  logic                     vbs_q, flag_q, pend_q;

  for (genvar gi = 0; gi < NUM_TIM; gi++) begin : g_tim
    localparam logic [CNT_W-1:0] RV = tim_field(RST_MODE.tim, gi);
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RV;
      else if (wr_en_i && wr_addr_i == RA_W'(gi)) q <= wr_data_i[CNT_W-1:0];
    end
    assign sh_flat[(NUM_TIM-1-gi)*CNT_W +: CNT_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_pol_q    <= RST_MODE.pol;
      sh_base_q   <= RST_MODE.base;
      sh_stride_q <= RST_MODE.stride;
    end else if (wr_en_i) begin
      if (wr_addr_i == RA_POL)    sh_pol_q    <= wr_data_i[POL_W-1:0];
      if (wr_addr_i == RA_BASE)   sh_base_q   <= wr_data_i[ADDR_W-1:0];
      if (wr_addr_i == RA_STRIDE) sh_stride_q <= wr_data_i[STRIDE_W-1:0];
    end
  end

  assign shadow = '{tim: tim_t'(sh_flat), pol: sh_pol_q, base: sh_base_q, stride: sh_stride_q};

  assign sh_valid = (shadow.tim.h.act != '0) && (shadow.tim.h.sync != '0) &&
                    (shadow.tim.v.act != '0) && (shadow.tim.v.sync != '0);
  assign next_mode    = sh_valid ? shadow : act_q;
  assign next_v_act_o = next_mode.tim.v.act;

  assign shadow_wr  = wr_en_i && (wr_addr_i <= RA_STRIDE);
  assign status_clr = wr_en_i && (wr_addr_i == RA_STATUS) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= RST_MODE;
      vbs_q  <= 1'b0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vbs_q <= commit_i;
      if (commit_i) act_q <= next_mode;
      if (commit_i)        flag_q <= 1'b1;
      else if (status_clr) flag_q <= 1'b0;
      if (shadow_wr)     pend_q <= 1'b1;
      else if (commit_i) pend_q <= 1'b0;
    end
  end

  assign act_o          = act_q;
  assign vblank_start_o = vbs_q;
  assign vblank_flag_o  = flag_q;
  assign pending_o      = pend_q;

  // R5
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q));
  // R9
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !sh_valid |=> $stable(act_q));
  // R8
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_wr |=> pend_q);
  // R7
  vbs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vbs_q |-> flag_q);
endmodule

// File: rtl/rtg_scan.sv
module rtg_scan import rtg_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tim_t                tim_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [CNT_W-1:0]    next_v_act_i,
  output logic                commit_o,
  output logic [CNT_W-1:0]    hcnt_o,
  output logic [CNT_W-1:0]    vcnt_o,
  output logic                de_raw_o,
  output logic                hs_raw_o,
  output logic                vs_raw_o,
  output logic [ADDR_W-1:0]   addr_o
);
  logic [CNT_W-1:0] hcnt_q, vcnt_q;
  logic h_act, v_act, h_last, v_last;

  rtg_window i_h_win (
    .ax_i(tim_i.h), .cnt_i(hcnt_q),
    .in_act_o(h_act), .in_sync_o(hs_raw_o), .at_last_o(h_last)
  );

  rtg_window i_v_win (
    .ax_i(tim_i.v), .cnt_i(vcnt_q),
    .in_act_o(v_act), .in_sync_o(vs_raw_o), .at_last_o(v_last)
  );

  // vertical blanking starts after the last active line
  assign commit_o = h_last && (vcnt_q == tim_i.v.act - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else if (commit_o) begin
      hcnt_q <= '0;
      vcnt_q <= next_v_act_i;
    end else if (h_last) begin
      hcnt_q <= '0;
      vcnt_q <= v_last ? '0 : vcnt_q + 1'b1;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign de_raw_o = h_act && v_act;
  assign addr_o   = de_raw_o ? base_i + ADDR_W'(vcnt_q) * ADDR_W'(stride_i) + ADDR_W'(hcnt_q)
                             : '0;
  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;

  // R2
  h_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_last |=> hcnt_q == $past(hcnt_q) + 1'b1);
  // R3
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_last && !commit_o && !v_last |=> vcnt_q == $past(vcnt_q) + 1'b1);
  // R5
  commit_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (hcnt_q == '0) && (vcnt_q == $past(next_v_act_i)));
endmodule

// File: rtl/rtg_launch.sv
module rtg_launch #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_LVL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_neg_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] neg_q;

  // falling-edge launch: data is centred on the panel's rising sample edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= RST_LVL;
    else         neg_q <= d_i;
  end

  assign q_o = sel_neg_i ? neg_q : d_i;

  // R4
  neg_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_neg_i && $past(rst_ni) |-> q_o == d_i);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import rtg_pkg::*; #(
  parameter int H_ACT      = 640,
  parameter int H_FP       = 24,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 40,
  parameter int V_ACT      = 480,
  parameter int V_FP       = 11,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 32,
  parameter int RST_POL    = 12,
  parameter int RST_BASE   = 0,
  parameter int RST_STRIDE = 640
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CNT_W-1:0]  x_o,
  output logic [CNT_W-1:0]  y_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              vblank_start_o,
  output logic              vblank_flag_o,
  output logic              commit_pending_o
);
  localparam mode_t RST_MODE = '{
    tim: '{h: '{act: CNT_W'(H_ACT), fp: CNT_W'(H_FP), sync: CNT_W'(H_SYNC), bp: CNT_W'(H_BP)},
           v: '{act: CNT_W'(V_ACT), fp: CNT_W'(V_FP), sync: CNT_W'(V_SYNC), bp: CNT_W'(V_BP)}},
    pol: POL_W'(RST_POL), base: ADDR_W'(RST_BASE), stride: STRIDE_W'(RST_STRIDE)};
  localparam logic [2:0] RST_IDLE = ~{RST_MODE.pol[POL_DE], RST_MODE.pol[POL_VS],
                                      RST_MODE.pol[POL_HS]};

  mode_t            act;
  logic [CNT_W-1:0] next_v_act;
  logic             commit, de_raw, hs_raw, vs_raw;
  logic [2:0]       panel_lvl, panel_out;

  rtg_cfg #(.RST_MODE(RST_MODE)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .commit_i(commit), .act_o(act), .next_v_act_o(next_v_act),
    .vblank_start_o, .vblank_flag_o, .pending_o(commit_pending_o)
  );

  rtg_scan i_scan (
    .clk_i, .rst_ni, .tim_i(act.tim), .base_i(act.base), .stride_i(act.stride),
    .next_v_act_i(next_v_act), .commit_o(commit), .hcnt_o(x_o), .vcnt_o(y_o),
    .de_raw_o(de_raw), .hs_raw_o(hs_raw), .vs_raw_o(vs_raw), .addr_o
  );

  assign panel_lvl = {~(de_raw ^ act.pol[POL_DE]),
                      ~(vs_raw ^ act.pol[POL_VS]),
                      ~(hs_raw ^ act.pol[POL_HS])};

  rtg_launch #(.W(3), .RST_LVL(RST_IDLE)) i_launch (
    .clk_i, .rst_ni, .sel_neg_i(act.pol[POL_PCLK]), .d_i(panel_lvl), .q_o(panel_out)
  );

  assign {de_o, vsync_o, hsync_o} = panel_out;
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_P = 10;
  localparam int HA = 6, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int STR = 6;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [23:0] wr_data = 0;
  logic        hsync, vsync, de, vbs, flag, pend;
  logic [11:0] x, y;
  logic [23:0] addr;

  int n_chk = 0, n_bad = 0;
  bit check_en = 0;

  // reference state
  int act_t[8], sh_t[8];
  int act_pol, sh_pol, act_base, sh_base, act_str, sh_str;
  int hc, vc;
  bit m_vbs, m_flag, m_pend;
  bit [2:0] prev_p;

  always #(CLK_P/2) clk = ~clk;

  raster_timing_gen #(.H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .RST_STRIDE(STR)) i_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y), .addr_o(addr),
    .vblank_start_o(vbs), .vblank_flag_o(flag), .commit_pending_o(pend));

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  function automatic bit [2:0] panel_of(int h, int v);
    bit hr, vr, dr;
    hr = h >= act_t[0] + act_t[1] && h < act_t[0] + act_t[1] + act_t[2];
    vr = v >= act_t[4] + act_t[5] && v < act_t[4] + act_t[5] + act_t[6];
    dr = h < act_t[0] && v < act_t[4];
    return {act_pol[2] ? dr : !dr, act_pol[1] ? vr : !vr, act_pol[0] ? hr : !hr};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_t = '{HA, HF, HS, HB, VA, VF, VS, VB};
      sh_t = act_t;
      act_pol = 12; sh_pol = 12; act_base = 0; sh_base = 0; act_str = STR; sh_str = STR;
      hc = 0; vc = 0; m_vbs = 0; m_flag = 0; m_pend = 0;
    end else begin
      int htot, vtot;
      bit cmt;
      htot = act_t[0] + act_t[1] + act_t[2] + act_t[3];
      vtot = act_t[4] + act_t[5] + act_t[6] + act_t[7];
      prev_p = panel_of(hc, vc);
      cmt = hc == htot - 1 && vc == act_t[4] - 1;
      m_vbs = cmt;
      if (cmt) begin
        if (sh_t[0] != 0 && sh_t[2] != 0 && sh_t[4] != 0 && sh_t[6] != 0) begin
          act_t = sh_t; act_pol = sh_pol; act_base = sh_base; act_str = sh_str;
        end
        hc = 0; vc = act_t[4]; m_flag = 1; m_pend = 0;
      end else if (hc == htot - 1) begin
        hc = 0; vc = (vc == vtot - 1) ? 0 : vc + 1;
      end else hc++;
      if (wr_en) begin
        if (wr_addr <= 7) begin sh_t[wr_addr] = int'(wr_data[11:0]); m_pend = 1; end
        else if (wr_addr == 8) begin sh_pol = int'(wr_data[3:0]); m_pend = 1; end
        else if (wr_addr == 9) begin sh_base = int'(wr_data); m_pend = 1; end
        else if (wr_addr == 10) begin sh_str = int'(wr_data[15:0]); m_pend = 1; end
        else if (wr_addr == 15 && wr_data[0] && !cmt) m_flag = 0;
      end
    end
  end

  // per-cycle comparison, away from both edges
  always @(posedge clk) begin
    #2;
    if (rst_n && check_en) begin
      bit [2:0] cur, ep;
      longint ea;
      cur = panel_of(hc, vc);
      ep = act_pol[3] ? prev_p : cur;
      ea = (hc < act_t[0] && vc < act_t[4]) ?
           (longint'(act_base) + longint'(vc) * act_str + hc) & 24'hFFFFFF : 0;
      chk("R2", "x", x, hc);
      chk("R3", "y", y, vc);
      chk("R2", "hsync", hsync, ep[0]);
      chk("R3", "vsync", vsync, ep[1]);
      chk("R4", "de", de, ep[2]);
      chk("R6", "addr", addr, ea);
      chk("R7", "vblank_start", vbs, m_vbs);
      chk("R7", "vblank_flag", flag, m_flag);
      chk("R8", "pending", pend, m_pend);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 24'(d);
    @(posedge clk); #3;
    wr_en = 0;
  endtask

  task automatic wait_vbs();
    do begin @(posedge clk); #3; end while (!vbs);
  endtask

  task automatic wait_xy(input int wx, input int wy);
    do begin @(posedge clk); #3; end while (!(x == 12'(wx) && y == 12'(wy)));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #3 rst_n = 1;
    // R1 reset state
    chk("R1", "x reset", x, 0);
    chk("R1", "y reset", y, 0);
    chk("R1", "addr reset", addr, 0);
    chk("R1", "vbs reset", vbs, 0);
    chk("R1", "flag reset", flag, 0);
    chk("R1", "pending reset", pend, 0);
    check_en = 1;
    cycles(2 * 104);

    // R5 mid-frame change held back
    wait_xy(0, 1);
    wr(2, 2);
    chk("R8", "pending after write", pend, 1);
    wait_vbs();
    chk("R8", "pending at commit", pend, 0);
    chk("R7", "flag at commit", flag, 1);
    chk("R5", "y at commit", y, VA);
    wr(15, 0);
    chk("R7", "flag kept on 0 write", flag, 1);
    wr(15, 1);
    chk("R7", "flag cleared", flag, 0);
    wr(11, 7);
    chk("R8", "unmapped write", pend, 0);
    wr(2, HS);
    wait_vbs();

    // R4 polarity sweep
    for (int p = 0; p < 16; p++) begin
      wr(8, p);
      wait_vbs();
      cycles(104);
    end
    wr(8, 12);
    wait_vbs();

    // R6 panning to the second stacked buffer
    wait_xy(0, 1);
    wr(9, VA * STR);
    chk("R5", "addr before commit", addr, STR + 1);
    wait_vbs();
    wait_xy(0, 0);
    chk("R6", "pan first pixel", addr, VA * STR);
    wait_xy(2, 1);
    chk("R6", "pan row1 col2", addr, VA * STR + STR + 2);
    wr(9, 0);
    wait_vbs();

    // R9 rejected shadow sets
    wr(2, 0);
    wait_vbs();
    chk("R9", "y after zero hsync", y, VA);
    chk("R9", "pending cleared", pend, 0);
    cycles(104);
    wr(2, HS);
    wr(4, 0);
    wait_vbs();
    chk("R9", "y after zero vact", y, VA);
    cycles(104);
    wr(4, VA);
    wait_vbs();
    cycles(104);

    // R10 800-column mode
    wr(0, 800); wr(1, 24); wr(2, 72); wr(3, 96);
    wr(4, 480); wr(5, 3); wr(6, 10); wr(7, 7);
    wr(8, 6); wr(10, 800);
    wait_vbs();
    chk("R10", "y at commit", y, 480);
    wait_xy(823, 485);
    chk("R10", "hsync before window", hsync, 1);
    chk("R10", "vsync in window", vsync, 1);
    cycles(1);
    chk("R10", "hsync at 824", hsync, 0);
    wait_xy(895, 485);
    chk("R10", "hsync at 895", hsync, 0);
    cycles(1);
    chk("R10", "hsync at 896", hsync, 1);
    wait_xy(0, 493);
    chk("R10", "vsync after window", vsync, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule